// File: doc/BRIEF.md
# Configurable Output Macrocell Bank

This block is the output stage of a sum-of-products logic array. It holds eight identical macrocells. Each cell receives eight product terms from an AND array outside the block. Each term can be switched off on its own. The cell ORs the terms that remain, can invert the sum, and sends the result out either straight through or through a D flip-flop on the shared clock. Each cell drives a data value and an output enable toward its pin. It also returns a feedback bit to the array, which lets the array build counters and state machines from registered cells.

Configuration comes from four sources. A global bit forces every cell to be combinational. A global mode bit is shared by all cells. Each cell also has its own mode bit and its own polarity bit. Decoding gives five cell behaviours:

- registered output, enabled by a shared enable input;
- combinational output in a registered bank, with term 0 used as the enable;
- combinational I/O, with term 0 used as the enable;
- dedicated combinational output, always enabled;
- dedicated input, with the driver off.

All pins are plain control and data wires with no valid/ready handshake. The product terms are level signals evaluated every cycle, and the block cannot hold off the array. A synchronous reset clears the flip-flops for testing.

Top module: `mcell_bank`

## Requirements
- R1: A term whose kill bit is 1 adds logic 0 to its cell's sum. Term t of cell n is bit n*8+t of `term_in`, and its kill bit is bit n*8+t of `cfg_kill`.
- R2: While `cfg_all_comb`=1, no cell's flip-flop loads on a clock edge, and no cell is in registered mode.
- R3: The triple (`cfg_all_comb`,`cfg_bank_mode`,`cfg_cell_mode[n]`) = (0,1,0) selects registered mode. In this mode the flip-flop loads the cell function on each rising edge, `cell_val[n]` shows the flip-flop value, and `cell_oe[n]` equals `oe_in`.
- R4: Registered mode returns the flip-flop value on `cell_fb[n]`. Every combinational output mode returns the combinational function value on `cell_fb[n]`.
- R5: With `cfg_invert[n]`=1, the cell function is the inverted sum. With `cfg_invert[n]`=0, it is the sum itself.
- R6: The triples (0,1,1) and (1,1,1) select a combinational output. In these modes the enable is term 0 ANDed with the inverse of its kill bit, and the sum uses only terms 1 to 7.
- R7: The triple (1,0,0) selects a dedicated combinational output. In this mode `cell_oe[n]`=1 and the sum uses all eight terms.
- R8: The triple (1,0,1), and every triple not named in R3, R6 or R7, selects input mode. In input mode `cell_oe[n]`=0, `cell_val[n]`=0 and `cell_fb[n]` equals `pad_in[n]`.
- R9: While `rst`=1 at a rising edge, every flip-flop clears to 0.
- R10: While `cfg_all_comb`=0 and `cfg_bank_mode`=1, each cell follows its own `cfg_cell_mode` bit. Registered and combinational cells can therefore run side by side.
- R11: A cell that is not in registered mode keeps its flip-flop value unchanged across clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock for all cell flip-flops |
| rst | input | 1 | Synchronous reset, active high, clears flip-flops |
| cfg_all_comb | input | 1 | Global bit: 1 forces every cell combinational |
| cfg_bank_mode | input | 1 | Global mode bit shared by all cells |
| cfg_cell_mode | input | 8 | Per-cell mode bit |
| cfg_invert | input | 8 | Per-cell polarity bit, 1 inverts the sum |
| cfg_kill | input | 64 | Per-term disable bits, bit n*8+t for cell n term t |
| term_in | input | 64 | Product terms from the AND array, bit n*8+t |
| oe_in | input | 1 | Shared output enable for registered cells |
| pad_in | input | 8 | Pin values returned as feedback in input mode |
| cell_val | output | 8 | Output data value per cell |
| cell_oe | output | 8 | Output enable per cell |
| cell_fb | output | 8 | Feedback to the AND array per cell |

## Verification
The clocked assertions assume that configuration, terms and `oe_in` are steady around each rising edge, and that the value seen just before an edge is the value the flip-flop captures. The bench changes every input one time unit after a rising edge. It then checks the outputs in the same cycle for combinational results and one edge later for registered results. This keeps each captured value well defined. Mode triples outside the five listed behaviours are driven on purpose, to show that they fall back to input mode.

// File: rtl/mcell_pkg.sv
package mcell_pkg;

  typedef enum logic [2:0] {
    CM_INPUT   = 3'd0,
    CM_DEDOUT  = 3'd1,
    CM_CMB_IO  = 3'd2,
    CM_CMB_REG = 3'd3,
    CM_REG     = 3'd4
  } cell_mode_e;

  function automatic cell_mode_e mode_decode(input logic all_comb,
                                             input logic bank_mode,
                                             input logic cell_mode);
    cell_mode_e m;
    unique case ({all_comb, bank_mode, cell_mode})
      3'b010:  m = CM_REG;
      3'b011:  m = CM_CMB_REG;
      3'b111:  m = CM_CMB_IO;
      3'b100:  m = CM_DEDOUT;
      default: m = CM_INPUT;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/mcell_decode.sv
module mcell_decode
  import mcell_pkg::*;
(
  input  logic       all_comb,
  input  logic       bank_mode,
  input  logic       cell_mode,
  output cell_mode_e mode,
  output logic       pt0_is_oe
);
  always_comb begin
    mode      = mode_decode(all_comb, bank_mode, cell_mode);
    pt0_is_oe = (mode == CM_CMB_IO) || (mode == CM_CMB_REG);
  end
endmodule

// File: rtl/mcell_sum.sv
module mcell_sum #(
  parameter int NTERM = 8
) (
  input  logic [NTERM-1:0] terms,
  input  logic [NTERM-1:0] kill,
  input  logic             pt0_is_oe,
  input  logic             invert,
  output logic             func,
  output logic             pt0_en
);
  logic [NTERM-1:0] live;
  logic [NTERM-1:0] sum_mask;

  always_comb begin
    live        = terms & ~kill;
    sum_mask    = '1;
    sum_mask[0] = ~pt0_is_oe;
    func        = (|(live & sum_mask)) ^ invert;
    pt0_en      = live[0];
  end
endmodule

// File: rtl/mcell_cell.sv
module mcell_cell
  import mcell_pkg::*;
#(
  parameter int NTERM = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             all_comb,
  input  logic             bank_mode,
  input  logic             cell_mode,
  input  logic             invert,
  input  logic [NTERM-1:0] terms,
  input  logic [NTERM-1:0] kill,
  input  logic             oe_in,
  input  logic             pad_in,
  output logic             out_val,
  output logic             out_oe,
  output logic             fb
);
  cell_mode_e mode;
  logic       pt0_is_oe;
  logic       func;
  logic       pt0_en;
  logic       q;

  mcell_decode u_dec (
    .all_comb (all_comb),
    .bank_mode(bank_mode),
    .cell_mode(cell_mode),
    .mode     (mode),
    .pt0_is_oe(pt0_is_oe)
  );

  mcell_sum #(.NTERM(NTERM)) u_sum (
    .terms    (terms),
    .kill     (kill),
    .pt0_is_oe(pt0_is_oe),
    .invert   (invert),
    .func     (func),
    .pt0_en   (pt0_en)
  );

  always_ff @(posedge clk) begin
    if (rst)                q <= 1'b0;
    else if (mode == CM_REG) q <= func;
  end

  always_comb begin
    unique case (mode)
      CM_REG: begin
        out_val = q;
        out_oe  = oe_in;
        fb      = q;
      end
      CM_CMB_REG, CM_CMB_IO: begin
        out_val = func;
        out_oe  = pt0_en;
        fb      = func;
      end
      CM_DEDOUT: begin
        out_val = func;
        out_oe  = 1'b1;
        fb      = func;
      end
      default: begin
        out_val = 1'b0;
        out_oe  = 1'b0;
        fb      = pad_in;
      end
    endcase
  end

  AST_REG_LOAD: assert property (@(posedge clk) disable iff (rst)
    (mode == CM_REG) |=> (q == $past(func))); // R3
  AST_HOLD_Q: assert property (@(posedge clk) disable iff (rst)
    (mode != CM_REG) |=> $stable(q)); // R11
  AST_FORCE_COMB: assert property (@(posedge clk) disable iff (rst)
    all_comb |-> (mode != CM_REG)); // R2
  AST_REG_FB: assert property (@(posedge clk) disable iff (rst)
    (mode == CM_REG) |-> (fb == q && out_val == q && out_oe == oe_in)); // R4
  AST_INPUT_OFF: assert property (@(posedge clk) disable iff (rst)
    (mode == CM_INPUT) |-> (!out_oe && !out_val && fb == pad_in)); // R8
  AST_DEDOUT_ON: assert property (@(posedge clk) disable iff (rst)
    (mode == CM_DEDOUT) |-> out_oe); // R7
endmodule

// File: rtl/mcell_bank.sv
module mcell_bank #(
  parameter int NCELL = 8,
  parameter int NTERM = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cfg_all_comb,
  input  logic                   cfg_bank_mode,
  input  logic [NCELL-1:0]       cfg_cell_mode,
  input  logic [NCELL-1:0]       cfg_invert,
  input  logic [NCELL*NTERM-1:0] cfg_kill,
  input  logic [NCELL*NTERM-1:0] term_in,
  input  logic                   oe_in,
  input  logic [NCELL-1:0]       pad_in,
  output logic [NCELL-1:0]       cell_val,
  output logic [NCELL-1:0]       cell_oe,
  output logic [NCELL-1:0]       cell_fb
);
  for (genvar n = 0; n < NCELL; n++) begin : g_cell
    mcell_cell #(.NTERM(NTERM)) u_cell (
      .clk      (clk),
      .rst      (rst),
      .all_comb (cfg_all_comb),
      .bank_mode(cfg_bank_mode),
      .cell_mode(cfg_cell_mode[n]),
      .invert   (cfg_invert[n]),
      .terms    (term_in[n*NTERM +: NTERM]),
      .kill     (cfg_kill[n*NTERM +: NTERM]),
      .oe_in    (oe_in),
      .pad_in   (pad_in[n]),
      .out_val  (cell_val[n]),
      .out_oe   (cell_oe[n]),
      .fb       (cell_fb[n])
    );
  end
endmodule

// File: tb/mcell_bank_tb.sv
module mcell_bank_tb;
  localparam int NC = 8;
  localparam int NT = 8;

  logic clk = 1'b0;
  logic rst;
  logic all_comb, bank_mode, oe_in;
  logic [NC-1:0] cell_mode, invert, pad_in;
  logic [NC*NT-1:0] kill, terms;
  logic [NC-1:0] cell_val, cell_oe, cell_fb;
  logic [NC-1:0] qm;
  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  mcell_bank u_dut (
    .clk(clk), .rst(rst), .cfg_all_comb(all_comb), .cfg_bank_mode(bank_mode),
    .cfg_cell_mode(cell_mode), .cfg_invert(invert), .cfg_kill(kill),
    .term_in(terms), .oe_in(oe_in), .pad_in(pad_in),
    .cell_val(cell_val), .cell_oe(cell_oe), .cell_fb(cell_fb)
  );

  // 0 input, 1 dedicated out, 2 comb I/O, 3 comb in registered bank, 4 registered
  function automatic int exp_mode(int n);
    if (!all_comb && bank_mode && !cell_mode[n]) return 4;
    if (!all_comb && bank_mode && cell_mode[n])  return 3;
    if (all_comb && bank_mode && cell_mode[n])   return 2;
    if (all_comb && !bank_mode && !cell_mode[n]) return 1;
    return 0;
  endfunction

  function automatic logic exp_func(int n);
    logic s = 1'b0;
    int m = exp_mode(n);
    for (int t = 0; t < NT; t++)
      if (!(t == 0 && (m == 2 || m == 3)))
        s = s | (terms[n*NT+t] & ~kill[n*NT+t]);
    return s ^ invert[n];
  endfunction

  task automatic cmp(string req, string what, int n, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s cell %0d: actual %b expected %b", req, what, n, act, exp);
    end
  endtask

  task automatic check_all(string req);
    for (int n = 0; n < NC; n++) begin
      int m = exp_mode(n);
      logic v, e, f;
      case (m)
        4: begin v = qm[n]; e = oe_in; f = qm[n]; end
        3, 2: begin v = exp_func(n); e = terms[n*NT] & ~kill[n*NT]; f = v; end
        1: begin v = exp_func(n); e = 1'b1; f = v; end
        default: begin v = 1'b0; e = 1'b0; f = pad_in[n]; end
      endcase
      cmp(req, "val", n, cell_val[n], v);
      cmp(req, "oe", n, cell_oe[n], e);
      cmp(req, "fb", n, cell_fb[n], f);
    end
  endtask

  task automatic step();
    logic [NC-1:0] nq;
    for (int n = 0; n < NC; n++)
      nq[n] = rst ? 1'b0 : (exp_mode(n) == 4 ? exp_func(n) : qm[n]);
    @(posedge clk);
    #1;
    qm = nq;
  endtask

  task automatic t_reset();
    rst = 1'b1; all_comb = 1'b0; bank_mode = 1'b1; cell_mode = '0;
    invert = '1; kill = '0; terms = '0; oe_in = 1'b1; pad_in = '0;
    step(); step();
    cmp("R9", "val after reset", 0, cell_val[0], 1'b0);
    check_all("R9");
    rst = 1'b0;
    #2;
  endtask

  task automatic t_dedout();
    all_comb = 1'b1; bank_mode = 1'b0; cell_mode = '0; invert = 8'hA5;
    kill = '0; terms = '0;
    for (int n = 0; n < NC; n++) terms[n*NT + (n % NT)] = n[0];
    #2; check_all("R7");
    check_all("R5");
    terms = '1; kill = '1; #2;
    for (int n = 0; n < NC; n++) cmp("R1", "all killed", n, cell_val[n], invert[n]);
    kill = {NC{8'h7F}}; terms = {NC{8'h80}}; invert = '0; #2;
    for (int n = 0; n < NC; n++) cmp("R1", "live term 7", n, cell_val[n], 1'b1);
    check_all("R1");
  endtask

  task automatic t_pt0oe();
    all_comb = 1'b1; bank_mode = 1'b1; cell_mode = '1; invert = '0; kill = '0;
    terms = {NC{8'h01}}; #2;
    for (int n = 0; n < NC; n++) begin
      cmp("R6", "pt0 excluded", n, cell_val[n], 1'b0);
      cmp("R6", "pt0 enables", n, cell_oe[n], 1'b1);
    end
    kill = {NC{8'h01}}; terms = {NC{8'h03}}; #2;
    for (int n = 0; n < NC; n++) cmp("R6", "killed pt0 oe", n, cell_oe[n], 1'b0);
    check_all("R6");
  endtask

  task automatic t_reg();
    all_comb = 1'b0; bank_mode = 1'b1; cell_mode = '0; invert = 8'h0F; kill = '0;
    oe_in = 1'b0; terms = '0;
    for (int n = 0; n < NC; n++) terms[n*NT + 3] = n[1];
    #2;
    check_all("R3");
    step();
    check_all("R3");
    check_all("R4");
    oe_in = 1'b1; terms = '1; #2;
    check_all("R4");
    step();
    check_all("R3");
  endtask

  task automatic t_mixed();
    all_comb = 1'b0; bank_mode = 1'b1; cell_mode = 8'h55; invert = 8'h33;
    kill = '0; terms = {NC{8'h12}}; oe_in = 1'b1; #2;
    check_all("R10");
    step();
    check_all("R10");
    terms = '0; #2;
    check_all("R10");
    check_all("R11");
    step();
    check_all("R11");
  endtask

  task automatic t_force();
    logic [NC-1:0] held;
    all_comb = 1'b0; bank_mode = 1'b1; cell_mode = '0; invert = '0; kill = '0;
    terms = '1; step();
    held = cell_val;
    all_comb = 1'b1; bank_mode = 1'b1; terms = '0; #2;
    check_all("R2");
    step(); step();
    all_comb = 1'b0; #2;
    for (int n = 0; n < NC; n++) cmp("R2", "flop not loaded", n, cell_val[n], held[n]);
    check_all("R11");
  endtask

  task automatic t_input();
    all_comb = 1'b1; bank_mode = 1'b0; cell_mode = '1; pad_in = 8'hC3;
    terms = '1; kill = '0; invert = '0; #2;
    for (int n = 0; n < NC; n++) cmp("R8", "input fb", n, cell_fb[n], pad_in[n]);
    check_all("R8");
    all_comb = 1'b0; bank_mode = 1'b0; cell_mode = 8'h0F; pad_in = 8'h3C; #2;
    check_all("R8");
    all_comb = 1'b1; bank_mode = 1'b1; cell_mode = '0; #2;
    check_all("R8");
    step();
    check_all("R8");
  endtask

  initial begin
    #1;
    t_reset();
    t_dedout();
    t_pt0oe();
    t_reg();
    t_mixed();
    t_force();
    t_input();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #200000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule